// File: doc/BRIEF.md
# Link-Event PHY Power Sequencer

This block controls the power command of a serial display transmitter PHY. Connect and disconnect events from the link detector are latched into an interrupt status register. A hardware sequencer acts on the events whose enable bits are set. It moves the PHY between off, regulator-only and transmit-on, so the transmitter is powered up only after a real link-connect event.

Software reaches the block over a simple single-cycle register bus. The bus has a write-one-to-clear status register and a pair of enable registers: writing ones to one of them sets enable bits, and writing ones to the other clears them. The interrupt output follows the enabled, pending status. A control input starts and stops the sequencer. When connect and disconnect are both pending, the sequencer switches the PHY off, drops both flags and returns to regulator-only. A cable that is really present then raises a fresh connect event. Every change of the power command is held for a programmable settle time before the next change.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset `phy_pwr_o` is 2'b00 (off), `irq_o` is low, and the status and enable registers read zero.
- R2: The status register is at offset 0x28. Link-connect is bit 25 and link-disconnect is bit 26. An event pulse sets its bit at the next clock edge. Writing a one clears the bit, and writing a zero leaves it unchanged. If an event and a clearing write happen in the same cycle, the bit stays set. All other status bits read zero.
- R3: Writing ones at offset 0x2C sets the matching enable bits, and writing ones at offset 0x30 clears them. Writing zeros to either register has no effect. A read at either offset returns the enable mask.
- R4: `irq_o` is high exactly when the status register ANDed with the enable mask is non-zero.
- R5: When `en_i` goes high while the sequencer is stopped, one edge clears every enable bit, clears both link status bits and sets `phy_pwr_o` to 2'b01 (regulator-only). Once the settle time has elapsed, both link enable bits are set.
- R6: When only an enabled connect is pending and settling is complete, the next edge sets `phy_pwr_o` to 2'b10 (transmit-on) and clears the connect bit.
- R7: When only an enabled disconnect is pending, the sequencer sets `phy_pwr_o` to 2'b01 and clears the disconnect bit.
- R8: When an enabled connect and an enabled disconnect are pending at the same time, the next edge sets `phy_pwr_o` to 2'b00 and clears both bits. After the settle time, `phy_pwr_o` returns to 2'b01.
- R9: After each change of `phy_pwr_o`, the next change comes no earlier than SETTLE_CYC+1 cycles later.
- R10: While `en_i` is low, `phy_pwr_o` goes to 2'b00 once settling allows it, and later link events do not change it.
- R11: `phy_pwr_o` enters 2'b10 only in the cycle after an enabled connect was pending. A connect event whose enable bit is clear leaves the power command unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sequencer run control |
| link_conn_i | input | 1 | Link-connect event pulse |
| link_disc_i | input | 1 | Link-disconnect event pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt, enabled status non-zero |
| phy_pwr_o | output | 2 | PHY power command: 00 off, 01 regulator-only, 10 transmit-on |

## Verification
The assertions assume that event inputs are synchronous, single-cycle pulses, and that register writes last one cycle with a stable address and data. Under those conditions the status, enable and power-command properties only have to reason one edge back. The stimulus drives every input on the falling edge and holds each event or write for exactly one cycle. It leaves more than the settle time between scenarios, except in the one case that deliberately sends a disconnect while a transmit-on change is still settling.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;
  typedef enum logic [1:0] {
    PWR_OFF = 2'b00,
    PWR_LDO = 2'b01,
    PWR_TX  = 2'b10
  } pwr_cmd_e;

  typedef enum logic [1:0] {
    SQ_STOP,
    SQ_ARM,
    SQ_RUN,
    SQ_RETRY
  } seq_state_e;

  localparam int unsigned CONN_BIT  = 25;
  localparam int unsigned DISC_BIT  = 26;
  localparam int unsigned OFS_STAT  = 'h28;
  localparam int unsigned OFS_ENSET = 'h2C;
  localparam int unsigned OFS_ENCLR = 'h30;
endpackage

// File: rtl/pps_regs.sv
module pps_regs
  import phy_pwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_conn_i,
  input  logic              ev_disc_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              seq_clr_conn_i,
  input  logic              seq_clr_disc_i,
  input  logic              seq_en_clr_all_i,
  input  logic              seq_en_set_link_i,
  output logic              pend_conn_o,
  output logic              pend_disc_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_ENSET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_ENCLR);
  localparam logic [DATA_W-1:0] LINK_MASK =
    (DATA_W'(1) << CONN_BIT) | (DATA_W'(1) << DISC_BIT);

  logic              st_conn_q, st_disc_q;
  logic [DATA_W-1:0] en_q, en_d, stat_vec;
  logic              wr_stat, wr_set, wr_clr;

  assign wr_stat = reg_we_i && (reg_addr_i == A_STAT);
  assign wr_set  = reg_we_i && (reg_addr_i == A_SET);
  assign wr_clr  = reg_we_i && (reg_addr_i == A_CLR);

  // events win over any clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_conn_q <= 1'b0;
      st_disc_q <= 1'b0;
    end else begin
      st_conn_q <= ev_conn_i |
        (st_conn_q & ~(wr_stat & reg_wdata_i[CONN_BIT]) & ~seq_clr_conn_i);
      st_disc_q <= ev_disc_i |
        (st_disc_q & ~(wr_stat & reg_wdata_i[DISC_BIT]) & ~seq_clr_disc_i);
    end
  end

  always_comb begin
    en_d = en_q;
    if (wr_clr) en_d = en_d & ~reg_wdata_i;
    if (wr_set) en_d = en_d | reg_wdata_i;
    if (seq_en_clr_all_i) en_d = '0;
    if (seq_en_set_link_i) en_d = en_d | LINK_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  always_comb begin
    stat_vec = '0;
    stat_vec[CONN_BIT] = st_conn_q;
    stat_vec[DISC_BIT] = st_disc_q;
  end

  always_comb begin
    unique case (reg_addr_i)
      A_STAT:       reg_rdata_o = stat_vec;
      A_SET, A_CLR: reg_rdata_o = en_q;
      default:      reg_rdata_o = '0;
    endcase
  end

  assign pend_conn_o = st_conn_q & en_q[CONN_BIT];
  assign pend_disc_o = st_disc_q & en_q[DISC_BIT];
  assign irq_o       = |(stat_vec & en_q);

  // R2
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[CONN_BIT] && !ev_conn_i) |=> !st_conn_q);
  // R2
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_disc_i |=> st_disc_q);
  // R3
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set && !seq_en_clr_all_i) |=> ((en_q & $past(reg_wdata_i)) == $past(reg_wdata_i)));
  // R3
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && !wr_set && !seq_en_set_link_i) |=> ((en_q & $past(reg_wdata_i)) == '0));
endmodule

// File: rtl/pps_settle.sv
module pps_settle
  import phy_pwr_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     chg_i,
  input  pwr_cmd_e cmd_i,
  output logic     ok_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (chg_i)        cnt_q <= CNT_W'(SETTLE_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign ok_o = (cnt_q == '0);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok_o |=> $stable(cmd_i));
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import phy_pwr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     settle_ok_i,
  input  logic     pend_conn_i,
  input  logic     pend_disc_i,
  output logic     clr_conn_o,
  output logic     clr_disc_o,
  output logic     en_clr_all_o,
  output logic     en_set_link_o,
  output logic     chg_o,
  output pwr_cmd_e phy_o
);
  seq_state_e state_q, state_d;
  pwr_cmd_e   phy_q, phy_d;

  always_comb begin
    state_d       = state_q;
    phy_d         = phy_q;
    clr_conn_o    = 1'b0;
    clr_disc_o    = 1'b0;
    en_clr_all_o  = 1'b0;
    en_set_link_o = 1'b0;
    if (settle_ok_i) begin
      if (!en_i) begin
        phy_d   = PWR_OFF;
        state_d = SQ_STOP;
      end else begin
        unique case (state_q)
          SQ_STOP: begin
            en_clr_all_o = 1'b1;
            clr_conn_o   = 1'b1;
            clr_disc_o   = 1'b1;
            phy_d        = PWR_LDO;
            state_d      = SQ_ARM;
          end
          SQ_ARM: begin
            en_set_link_o = 1'b1;
            state_d       = SQ_RUN;
          end
          SQ_RUN: begin
            if (pend_conn_i && pend_disc_i) begin
              phy_d      = PWR_OFF;
              clr_conn_o = 1'b1;
              clr_disc_o = 1'b1;
              state_d    = SQ_RETRY;
            end else if (pend_conn_i) begin
              phy_d      = PWR_TX;
              clr_conn_o = 1'b1;
            end else if (pend_disc_i) begin
              phy_d      = PWR_LDO;
              clr_disc_o = 1'b1;
            end
          end
          SQ_RETRY: begin
            phy_d   = PWR_LDO;
            state_d = SQ_RUN;
          end
          default: state_d = SQ_STOP;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_STOP;
      phy_q   <= PWR_OFF;
    end else begin
      state_q <= state_d;
      phy_q   <= phy_d;
    end
  end

  assign chg_o = (phy_d != phy_q);
  assign phy_o = phy_q;

  // R11
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_q == PWR_TX && $past(phy_q) != PWR_TX) |-> $past(pend_conn_i));
  // R10
  off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && settle_ok_i) |=> (phy_q == PWR_OFF));
  // R8
  retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_RUN && en_i && settle_ok_i && pend_conn_i && pend_disc_i)
      |=> (phy_q == PWR_OFF && state_q == SQ_RETRY));
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              link_conn_i,
  input  logic              link_disc_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [1:0]        phy_pwr_o
);
  logic     pend_conn, pend_disc, clr_conn, clr_disc;
  logic     en_clr_all, en_set_link, settle_ok, chg;
  pwr_cmd_e phy_cmd;

  pps_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .ev_conn_i         (link_conn_i),
    .ev_disc_i         (link_disc_i),
    .reg_we_i          (reg_we_i),
    .reg_addr_i        (reg_addr_i),
    .reg_wdata_i       (reg_wdata_i),
    .reg_rdata_o       (reg_rdata_o),
    .seq_clr_conn_i    (clr_conn),
    .seq_clr_disc_i    (clr_disc),
    .seq_en_clr_all_i  (en_clr_all),
    .seq_en_set_link_i (en_set_link),
    .pend_conn_o       (pend_conn),
    .pend_disc_o       (pend_disc),
    .irq_o             (irq_o)
  );

  pps_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chg_i  (chg),
    .cmd_i  (phy_cmd),
    .ok_o   (settle_ok)
  );

  pps_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .settle_ok_i   (settle_ok),
    .pend_conn_i   (pend_conn),
    .pend_disc_i   (pend_disc),
    .clr_conn_o    (clr_conn),
    .clr_disc_o    (clr_disc),
    .en_clr_all_o  (en_clr_all),
    .en_set_link_o (en_set_link),
    .chg_o         (chg),
    .phy_o         (phy_cmd)
  );

  assign phy_pwr_o = phy_cmd;
endmodule

// File: tb/phy_pwr_seq_tb_top.sv
module phy_pwr_seq_tb_top;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam int unsigned ST = 4;
  localparam logic [AW-1:0] A_STAT = 8'h28, A_SET = 8'h2C, A_CLR = 8'h30;
  localparam logic [DW-1:0] B_CONN = 32'h0200_0000, B_DISC = 32'h0400_0000;
  localparam logic [1:0] P_OFF = 2'b00, P_LDO = 2'b01, P_TX = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, l_conn = 1'b0, l_disc = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic irq;
  logic [1:0] pwr;

  int checks = 0, errors = 0, cyc = 0, last_chg = -100;
  logic [1:0] exp_q[$];
  logic [1:0] last_pwr = 2'b00;

  always #10 clk = ~clk;

  phy_pwr_seq #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(ST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .link_conn_i(l_conn), .link_disc_i(l_disc),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .phy_pwr_o(pwr)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse(logic c, logic dd);
    @(negedge clk); l_conn = c; l_disc = dd;
    @(negedge clk); l_conn = 1'b0; l_disc = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every power-command change must match the queue head
  always @(negedge clk) begin
    cyc++;
    if (rst_n && pwr !== last_pwr) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10/R11 unexpected change act=%b exp=%b", pwr, last_pwr);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        if (pwr !== e) begin
          errors++;
          $display("FAIL R5-sequence order act=%b exp=%b", pwr, e);
        end
      end
      // R9 spacing between changes
      checks++;
      if (cyc - last_chg < ST + 1) begin
        errors++;
        $display("FAIL R9 gap act=%0d exp>=%0d", cyc - last_chg, ST + 1);
      end
      last_chg = cyc;
      last_pwr = pwr;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    idle(3);
    rst_n = 1'b1;
    // R1
    rd(A_STAT, d); chk("R1 status", d, '0);
    rd(A_SET, d);  chk("R1 enable", d, '0);
    chk("R1 irq", DW'(irq), '0);
    chk("R1 pwr", DW'(pwr), '0);

    // R2 / R4 with sequencer stopped
    pulse(1, 0);
    rd(A_STAT, d); chk("R2 conn set", d, B_CONN);
    chk("R4 irq masked", DW'(irq), '0);
    wr(A_SET, B_CONN);
    rd(A_SET, d); chk("R3 set", d, B_CONN);
    rd(A_CLR, d); chk("R3 read at clr", d, B_CONN);
    chk("R4 irq on", DW'(irq), 1);
    wr(A_SET, '0); wr(A_CLR, '0);
    rd(A_SET, d); chk("R3 zeros no effect", d, B_CONN);
    wr(A_STAT, '0);
    rd(A_STAT, d); chk("R2 zero write keeps", d, B_CONN);
    wr(A_STAT, B_CONN);
    rd(A_STAT, d); chk("R2 w1c", d, '0);
    chk("R4 irq off", DW'(irq), '0);
    // R2 event and clear in same cycle
    @(negedge clk); l_disc = 1'b1; we = 1'b1; addr = A_STAT; wdata = B_DISC;
    @(negedge clk); l_disc = 1'b0; we = 1'b0; wdata = '0;
    rd(A_STAT, d); chk("R2 set wins", d, B_DISC);
    wr(A_CLR, B_CONN);
    rd(A_CLR, d); chk("R3 clr", d, '0);
    wr(A_STAT, '1);
    rd(A_STAT, d); chk("R2 clear all", d, '0);
    chk("R10 still off", DW'(pwr), DW'(P_OFF));

    // R5 enable sequence, with a stale connect flag
    pulse(1, 0);
    wr(A_SET, B_DISC);
    exp_q.push_back(P_LDO);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    chk("R5 ldo", DW'(pwr), DW'(P_LDO));
    rd(A_STAT, d); chk("R5 status cleared", d, '0);
    rd(A_SET, d);  chk("R5 enables cleared", d, '0);
    idle(8);
    rd(A_SET, d);  chk("R5 link enables", d, B_CONN | B_DISC);

    // R6
    exp_q.push_back(P_TX);
    pulse(1, 0);
    chk("R6 before", DW'(pwr), DW'(P_LDO));
    @(negedge clk);
    chk("R6 tx", DW'(pwr), DW'(P_TX));
    rd(A_STAT, d); chk("R6 conn cleared", d, '0);
    idle(10);

    // R7
    exp_q.push_back(P_LDO);
    pulse(0, 1);
    @(negedge clk);
    chk("R7 ldo", DW'(pwr), DW'(P_LDO));
    rd(A_STAT, d); chk("R7 disc cleared", d, '0);
    idle(10);

    // R8
    exp_q.push_back(P_OFF);
    exp_q.push_back(P_LDO);
    pulse(1, 1);
    @(negedge clk);
    chk("R8 off", DW'(pwr), DW'(P_OFF));
    rd(A_STAT, d); chk("R8 both cleared", d, '0);
    idle(10);
    chk("R8 back to ldo", DW'(pwr), DW'(P_LDO));

    // R11 masked connect does nothing
    wr(A_CLR, B_CONN);
    pulse(1, 0);
    idle(10);
    chk("R11 no tx", DW'(pwr), DW'(P_LDO));
    chk("R11 irq", DW'(irq), '0);
    rd(A_STAT, d); chk("R11 flag kept", d, B_CONN);

    // R9 unmask, then a disconnect during settling
    exp_q.push_back(P_TX);
    exp_q.push_back(P_LDO);
    wr(A_SET, B_CONN);
    pulse(0, 1);
    chk("R9 held", DW'(pwr), DW'(P_TX));
    @(negedge clk);
    chk("R9 held2", DW'(pwr), DW'(P_TX));
    idle(10);
    chk("R9 ldo after settle", DW'(pwr), DW'(P_LDO));

    // R10
    exp_q.push_back(P_OFF);
    @(negedge clk); en = 1'b0;
    idle(10);
    chk("R10 off", DW'(pwr), DW'(P_OFF));
    pulse(1, 0);
    idle(10);
    chk("R10 ignore event", DW'(pwr), DW'(P_OFF));

    chk("R5-R10 queue drained", DW'(exp_q.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule